// File: doc/BRIEF.md
# Search-Line Alignment Buffer

This block collects one line of a motion-search window, one pixel per accepted cycle, and hands the whole line to a processing array in a single parallel transfer. The array is wired as a ring: its last passive columns wrap around to meet the first active block. A line fed in while the sweep runs one way therefore needs its pixels placed straight, and a line fed in while the sweep runs the other way needs them rotated.

The storage is one chain of LINE_L registers cut into two sub-chains, a lower one of LEN_A stages and an upper one of LEN_B stages. Two input multiplexers pick the order in which the serial stream passes through the two parts. In straight order the stream enters the upper part first and flows on into the lower part. In swapped order it enters the lower part first and flows on into the upper part. The parallel output always reads the lower part into the low slots and the upper part into the high slots, so the swapped order gives the line rotated by LEN_B slots at no added cost.

The sweep direction is sampled on the first pixel of each line. A transfer strobe copies the chain into the output register and opens a new line.

Top module: `swin_align_buf`

## Requirements
- R1: While reset is asserted, and after it is released, every parallel output slot reads zero until the first transfer.
- R2: The line length is LINE_L = CORES*ceil(SRCH_2P/CORES) + BLK_N - 1. The lower sub-chain has LEN_A = CORES*(ACT_W+GAP_M) - GAP_M stages and the upper has LEN_B = GAP_M + BLK_N - 1 stages, where GAP_M = ceil(SRCH_2P/CORES) - ACT_W. With the defaults, LINE_L = 17, LEN_A = 11 and LEN_B = 6.
- R3: With direction 0 (straight), after a transfer, output slot j (bits j*PIX_W and up) holds the j-th pixel of the line, counting the first accepted pixel as 0.
- R4: With direction 1 (swapped), after a transfer, output slot j holds pixel number (j + LEN_B) mod LINE_L of the line.
- R5: The direction is taken from the first accepted pixel of a line. Changes to it during the rest of the line have no effect until the next transfer.
- R6: In a cycle where pixel-valid is low, the chain does not shift and the pixel input is ignored.
- R7: The parallel output changes only in the cycle after a transfer strobe, and otherwise holds its value.
- R8: When valid and the transfer strobe arrive in the same cycle, the transfer takes the line without that pixel. That pixel becomes pixel 0 of the next line, with the direction given in that cycle.
- R9: If more than LINE_L pixels arrive before a transfer, the transfer delivers the last LINE_L of them, in the arrangement of R3 or R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_vld_i | input | 1 | Serial pixel is valid this cycle |
| pix_i | input | PIX_W | Serial pixel |
| swap_dir_i | input | 1 | Sweep direction: 0 straight, 1 swapped |
| xfer_i | input | 1 | Copy the line to the parallel output and start a new line |
| line_o | output | LINE_L*PIX_W | Parallel line, slot j at bits j*PIX_W |

## Verification
The bench loads lines of numbered pixels in both directions and checks the full permutation.

- **Wrong split point.** The rotation distance equals the upper sub-chain length. A wrong split or a swapped multiplexer shows up as a rotation by the wrong amount.
- **Direction not latched.** A direction flip in the middle of a line catches a design that samples the direction on every cycle. Such a design would split the line across both orders.
- **Simultaneous pixel and strobe.** A valid pixel in the same cycle as the strobe catches a design that puts that pixel into the old line, or that gives the new line the old direction.
- **Valid gaps.** Gaps in valid, with garbage on the pixel input, expose a chain that shifts without valid.
- **Overlong lines.** Lines longer than LINE_L pixels confirm that only the newest pixels survive.

// File: rtl/swin_pkg.sv
package swin_pkg;
  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/swin_chain.sv
module swin_chain #(
  parameter int PIX_W = 8,
  parameter int DEPTH = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   shift_i,
  input  logic [PIX_W-1:0]       d_i,
  output logic [PIX_W-1:0]       tail_o,
  output logic [DEPTH*PIX_W-1:0] q_flat_o
);
  localparam int TOP = DEPTH - 1;

  logic [PIX_W-1:0] stg_q [DEPTH];
  logic [PIX_W-1:0] stg_d [DEPTH];

  // next-state: stage TOP takes the input, the others take the stage above
  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_nxt
      if (i == TOP) begin : g_head
        always_comb stg_d[i] = shift_i ? d_i : stg_q[i];
      end else begin : g_body
        always_comb stg_d[i] = shift_i ? stg_q[i+1] : stg_q[i];
      end
    end
  endgenerate

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[i] <= '0;
        else        stg_q[i] <= stg_d[i];
      end
      assign q_flat_o[i*PIX_W +: PIX_W] = stg_q[i];
    end
  endgenerate

  assign tail_o = stg_q[0];

  assert_chain_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_i |=> $stable(q_flat_o));
  assert_chain_head_R3: assert property (@(posedge clk) disable iff (!rst_n)
    shift_i |=> (q_flat_o[TOP*PIX_W +: PIX_W] == $past(d_i)));
endmodule

// File: rtl/swin_line_ctrl.sv
module swin_line_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic vld_i,
  input  logic xfer_i,
  input  logic dir_i,
  output logic swap_o
);
  logic act_q, act_d;
  logic dir_q, dir_d;
  logic open_line;

  // a pixel opens a line when no line is open or a transfer closes the old one
  assign open_line = vld_i && (!act_q || xfer_i);

  always_comb begin
    act_d = act_q;
    dir_d = dir_q;
    if (xfer_i)     act_d = vld_i;
    else if (vld_i) act_d = 1'b1;
    if (open_line)  dir_d = dir_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      dir_q <= 1'b0;
    end else begin
      act_q <= act_d;
      dir_q <= dir_d;
    end
  end

  assign swap_o = (act_q && !xfer_i) ? dir_q : dir_i;

  assert_dir_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !xfer_i) |=> $stable(dir_q));
  assert_new_line_dir_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && xfer_i) |=> (act_q && (dir_q == $past(dir_i))));
endmodule

// File: rtl/swin_align_buf.sv
module swin_align_buf #(
  parameter int PIX_W   = 8,
  parameter int BLK_N   = 4,
  parameter int SRCH_2P = 14,
  parameter int CORES   = 2,
  parameter int ACT_W   = 4,
  localparam int PER_CORE = swin_pkg::cdiv(SRCH_2P, CORES),
  localparam int GAP_M    = PER_CORE - ACT_W,
  localparam int LINE_L   = CORES * PER_CORE + BLK_N - 1,
  localparam int LEN_A    = CORES * (ACT_W + GAP_M) - GAP_M,
  localparam int LEN_B    = GAP_M + BLK_N - 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pix_vld_i,
  input  logic [PIX_W-1:0]        pix_i,
  input  logic                    swap_dir_i,
  input  logic                    xfer_i,
  output logic [LINE_L*PIX_W-1:0] line_o
);
  logic                    swap;
  logic [PIX_W-1:0]        a_in, b_in, a_tail, b_tail;
  logic [LEN_A*PIX_W-1:0]  a_flat;
  logic [LEN_B*PIX_W-1:0]  b_flat;
  logic [LINE_L*PIX_W-1:0] par_line, line_d;

  swin_line_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .vld_i  (pix_vld_i),
    .xfer_i (xfer_i),
    .dir_i  (swap_dir_i),
    .swap_o (swap)
  );

  // the two link multiplexers: the order of the sub-chains follows the sweep direction
  assign a_in = swap ? pix_i  : b_tail;
  assign b_in = swap ? a_tail : pix_i;

  swin_chain #(.PIX_W(PIX_W), .DEPTH(LEN_A)) u_chain_a (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_i  (pix_vld_i),
    .d_i      (a_in),
    .tail_o   (a_tail),
    .q_flat_o (a_flat)
  );

  swin_chain #(.PIX_W(PIX_W), .DEPTH(LEN_B)) u_chain_b (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_i  (pix_vld_i),
    .d_i      (b_in),
    .tail_o   (b_tail),
    .q_flat_o (b_flat)
  );

  // fixed output wiring: lower sub-chain in the low slots
  assign par_line = {b_flat, a_flat};

  always_comb line_d = xfer_i ? par_line : line_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_o <= '0;
    else        line_o <= line_d;
  end

  assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_i |=> $stable(line_o));
  assert_swap_link_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_vld_i && swap) |=> (b_flat[(LEN_B-1)*PIX_W +: PIX_W] == $past(a_tail)));
  assert_straight_link_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_vld_i && !swap) |=> (a_flat[(LEN_A-1)*PIX_W +: PIX_W] == $past(b_tail)));
endmodule

// File: tb/swin_align_buf_bench.sv
module swin_align_buf_bench;
  localparam int PIX_W   = 8;
  localparam int BLK_N   = 4;
  localparam int SRCH_2P = 14;
  localparam int CORES   = 2;
  localparam int ACT_W   = 4;
  // R2: lengths worked out from the requirement formulas
  localparam int PCORE = (SRCH_2P + CORES - 1) / CORES;
  localparam int GAP   = PCORE - ACT_W;
  localparam int LL    = CORES * PCORE + BLK_N - 1;
  localparam int LB    = GAP + BLK_N - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_vld_i = 1'b0;
  logic [PIX_W-1:0] pix_i = '0;
  logic swap_dir_i = 1'b0;
  logic xfer_i = 1'b0;
  logic [LL*PIX_W-1:0] line_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [PIX_W-1:0] hist [LL];
  logic [LL*PIX_W-1:0] expv;

  localparam logic [8:0] VEC [6] = '{
    {1'b0, 8'h10}, {1'b1, 8'h40}, {1'b1, 8'h80},
    {1'b0, 8'hA0}, {1'b1, 8'hC3}, {1'b0, 8'hE7}};

  always #5 clk = ~clk;

  swin_align_buf #(.PIX_W(PIX_W), .BLK_N(BLK_N), .SRCH_2P(SRCH_2P),
                   .CORES(CORES), .ACT_W(ACT_W)) u_swin_align_buf (
    .clk(clk), .rst_n(rst_n), .pix_vld_i(pix_vld_i), .pix_i(pix_i),
    .swap_dir_i(swap_dir_i), .xfer_i(xfer_i), .line_o(line_o));

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog: run hung, actual running expected finished");
    n_chk++; n_bad++;
    summary();
  end

  task automatic check(input string req, input logic [LL*PIX_W-1:0] act,
                       input logic [LL*PIX_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [LL*PIX_W-1:0] build(input logic d);
    logic [LL*PIX_W-1:0] v;
    for (int j = 0; j < LL; j++)
      v[j*PIX_W +: PIX_W] = d ? hist[(j + LB) % LL] : hist[j];
    return v;
  endfunction

  task automatic push(input logic [PIX_W-1:0] v, input logic d);
    pix_i = v; swap_dir_i = d; pix_vld_i = 1'b1;
    @(negedge clk);
    pix_vld_i = 1'b0;
    for (int k = 0; k < LL - 1; k++) hist[k] = hist[k+1];
    hist[LL-1] = v;
  endtask

  task automatic xfer();
    xfer_i = 1'b1;
    @(negedge clk);
    xfer_i = 1'b0;
  endtask

  task automatic load_line(input logic [PIX_W-1:0] seed, input logic d, input int cnt);
    for (int k = 0; k < cnt; k++) push(seed + PIX_W'(k), d);
  endtask

  initial begin
    for (int k = 0; k < LL; k++) hist[k] = '0;
    repeat (3) @(negedge clk);
    check("R1 during reset", line_o, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", line_o, '0);

    // table walk: one full line per entry, direction 0 checks R3, 1 checks R4
    for (int t = 0; t < 6; t++) begin
      load_line(VEC[t][7:0], VEC[t][8], LL);
      expv = build(VEC[t][8]);
      xfer();
      check(VEC[t][8] ? "R4 swapped line" : "R3 straight line", line_o, expv);
    end

    // R7: pixels arriving without a strobe leave the output alone
    expv = line_o;
    load_line(8'h55, 1'b0, 5);
    check("R7 hold without strobe", line_o, expv);
    load_line(8'h5A, 1'b0, LL - 5);
    expv = build(1'b0);
    xfer();
    check("R3 line after hold", line_o, expv);

    // R6: gaps with garbage on the pixel input
    for (int k = 0; k < LL; k++) begin
      push(8'h20 + PIX_W'(k), 1'b1);
      pix_i = 8'hFF; swap_dir_i = 1'b0;
      @(negedge clk);
    end
    expv = build(1'b1);
    xfer();
    check("R6 valid gaps ignored", line_o, expv);

    // R5: direction flipped in mid-line has no effect
    push(8'h60, 1'b1);
    for (int k = 1; k < LL; k++) push(8'h60 + PIX_W'(k), 1'b0);
    expv = build(1'b1);
    xfer();
    check("R5 mid-line direction ignored", line_o, expv);
    push(8'h90, 1'b0);
    for (int k = 1; k < LL; k++) push(8'h90 + PIX_W'(k), 1'b1);
    expv = build(1'b0);
    xfer();
    check("R5 mid-line direction ignored, straight", line_o, expv);

    // R9: overlong lines keep the newest pixels
    load_line(8'h01, 1'b0, LL + 3);
    expv = build(1'b0);
    xfer();
    check("R9 overflow straight", line_o, expv);
    load_line(8'h31, 1'b1, LL + 4);
    expv = build(1'b1);
    xfer();
    check("R9 overflow swapped", line_o, expv);

    // R8: pixel and strobe in the same cycle
    load_line(8'h70, 1'b0, LL);
    expv = build(1'b0);
    xfer_i = 1'b1;
    push(8'hD0, 1'b1);
    xfer_i = 1'b0;
    check("R8 snapshot excludes pixel", line_o, expv);
    for (int k = 1; k < LL; k++) push(8'hD0 + PIX_W'(k), 1'b0);
    expv = build(1'b1);
    xfer();
    check("R8 pixel opens next line", line_o, expv);

    summary();
  end
endmodule